// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor whose low address byte and data byte share the same pins. A requester gives it a cycle kind, a 16-bit address and a write byte. The sequencer then steps through the T-states of that cycle on the pins. It drives the upper address byte and a shared low byte with its own output enable. It also drives an address latch strobe, active-low read and write strobes, and a three-bit status code. When the cycle ends it returns the captured read byte together with a one-clock done pulse.

Each T-state spans two clocks. The first clock is the early half and the second is the late half, so the late half starts at the middle of the T-state. An opcode fetch takes four T-states. The other four kinds take three. The request fields are latched when the cycle starts, so the requester may change them during the cycle without effect.

Top module: `bus_cycle_seq`

## Requirements
- R1: Counting from the clock edge that accepts a request, `rsp_done` is high in clock 8 for an opcode fetch and in clock 6 for every other kind. Each T-state spans two clocks. Kind codes: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write.
- R2: For the whole cycle, `bus_status` = {io/mem, s1, s0} holds the kind's code: fetch 3'b011, memory read 3'b010, memory write 3'b001, I/O read 3'b110, I/O write 3'b101.
- R3: `bus_ale` is high only in clock 1 (first half of T1). In that clock `bus_ad_oe` is high and `bus_ad_out` carries the low address byte.
- R4: A memory cycle drives `bus_addr_hi` = addr[15:8] and the low byte addr[7:0]. An I/O cycle drives the port number addr[7:0] on both bytes.
- R5: For a fetch or a read, `bus_rd_n` is low in clocks 3 to 5 (start of T2 until the middle of T3), and `bus_ad_oe` is low from clock 2 through clock 6.
- R6: The byte on `bus_ad_in` in clock 5 (the last clock with read strobe low) is returned on `rsp_rdata` when `rsp_done` is high.
- R7: For a write, `bus_wr_n` is low in clocks 3 to 5, and `bus_ad_out` carries the write byte with `bus_ad_oe` high in those same clocks.
- R8: In T4 of an opcode fetch (clocks 7 and 8) no strobe is active and `bus_ad_oe` is low.
- R9: When idle, and in the clock after any synchronous reset (even mid-cycle), `bus_rd_n` and `bus_wr_n` are high and `bus_ale`, `bus_ad_oe`, `rsp_done` are low, with `bus_status` = 3'b000.
- R10: `rsp_done` is a single-clock pulse. A request with kind code 5, 6 or 7 is ignored: no strobe, no status and no done.
- R11: Request fields are latched at acceptance. Changing `req_addr` or `req_wdata` while a cycle runs does not change it, and a held `req_valid` does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per T-state |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte captured by the last read or fetch |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| bus_addr_hi | output | 8 | Upper address byte |
| bus_ad_out | output | 8 | Shared low address / data byte, outgoing |
| bus_ad_oe | output | 1 | Output enable for the shared byte |
| bus_ad_in | input | 8 | Shared byte, incoming |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_status | output | 3 | {io/mem, s1, s0} cycle status |

## Verification
Two functions can fall in the same clock here. In clock 5 of a read, the data capture and the read strobe's last low clock coincide with the handover of the shared byte away from the block. At the same time, the requester may be changing its request fields. The bench presents the memory byte only while the read strobe is low, and it inverts the address and write byte just after acceptance. A correct result therefore shows both that capture happens in the right clock and that the latched copy alone steers the cycle. A reset applied mid-write and an illegal kind held for many clocks cover the remaining overlap, in which the cycle start meets a clearing condition.

// File: rtl/bus_seq_pkg.sv
// Shared kinds, status codes and helpers for the bus cycle sequencer.
// Assumes kind codes 0..4 are the only legal ones.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } kind_e;

    // True when the code names a supported cycle kind
    function automatic logic kind_legal(input logic [2:0] k);
        return (k <= 3'd4);
    endfunction

    // True for kinds that drive the read strobe
    function automatic logic kind_reads(input logic [2:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    // True for kinds that drive the write strobe
    function automatic logic kind_writes(input logic [2:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    // True for port-space kinds
    function automatic logic kind_is_io(input logic [2:0] k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    // Status triple {io/mem, s1, s0} for a kind
    function automatic logic [2:0] kind_status(input logic [2:0] k);
        logic [2:0] s;
        case (k)
            K_FETCH: s = 3'b011;
            K_MRD:   s = 3'b010;
            K_MWR:   s = 3'b001;
            K_IORD:  s = 3'b110;
            K_IOWR:  s = 3'b101;
            default: s = 3'b000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bus_tstate_ctrl.sv
// T-state counter: steps T1..Tn, two clocks per T-state (phase 0 early
// half, phase 1 late half), flags the final clock of a cycle.
// Assumes start is only meaningful while idle; cyc_len is stable in a cycle.
module bus_tstate_ctrl #(
    parameter int MAX_T = 4,
    localparam int TW   = $clog2(MAX_T + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] cyc_len,
    output logic [TW-1:0] tnum,
    output logic          phase,
    output logic          last
);

    logic active;

    assign active = (tnum != '0);
    assign last   = active && phase && (tnum == cyc_len);

    // Advance half-T phase and T-state number, return to idle after the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tnum  <= '0;
            phase <= 1'b0;
        end else if (!active) begin
            if (start) begin
                tnum  <= TW'(1);
                phase <= 1'b0;
            end
        end else begin
            phase <= ~phase;
            if (phase) begin
                if (tnum == cyc_len) tnum <= '0;
                else                 tnum <= tnum + TW'(1);
            end
        end
    end

    assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (tnum == '0));

    assert_half_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (phase != $past(phase)));

endmodule

// File: rtl/bus_strobe_gen.sv
// Decodes T-state and phase into the bus strobes, the shared-byte enable,
// the address/data select and the read capture pulse.
// Assumes strobe timing sits in T1..T3; later T-states are strobe-free.
module bus_strobe_gen #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tnum,
    input  logic          phase,
    input  logic          rd_kind,
    input  logic          wr_kind,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ad_oe,
    output logic          sel_addr,
    output logic          capture
);

    logic in_t1, in_t2, in_t3;
    logic strobe_win;

    assign in_t1 = (tnum == TW'(1));
    assign in_t2 = (tnum == TW'(2));
    assign in_t3 = (tnum == TW'(3));
    // Strobe window: all of T2 plus the early half of T3
    assign strobe_win = in_t2 || (in_t3 && !phase);

    // Combine window with kind into the pin-level controls
    always_comb begin
        ale      = in_t1 && !phase;
        sel_addr = in_t1 && !phase;
        rd_n     = !(rd_kind && strobe_win);
        wr_n     = !(wr_kind && strobe_win);
        ad_oe    = (in_t1 && !phase) || (wr_kind && strobe_win);
        capture  = rd_kind && in_t3 && !phase;
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

endmodule

// File: rtl/bus_req_path.sv
// Request latch and data path: holds the accepted request, forms the
// address bytes and status, muxes the shared byte and captures read data.
// Assumes the address is exactly two data bytes wide.
module bus_req_path
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sel_addr,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    output logic [2:0]        kind_q,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic [2:0]        status,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] lo_byte;

    // Latch the request when a cycle is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= 3'd0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the shared byte in the final read-strobe clock
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= ad_in;
    end

    // Form address bytes, status and the outgoing shared byte
    always_comb begin
        lo_byte = addr_q[DATA_W-1:0];
        if (!active) begin
            addr_hi = '0;
            status  = 3'b000;
        end else begin
            addr_hi = kind_is_io(kind_q) ? lo_byte : addr_q[ADDR_W-1:DATA_W];
            status  = kind_status(kind_q);
        end
        ad_out = sel_addr ? lo_byte : wdata_q;
    end

    assert_status_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(status));

    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(addr_hi));

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the multiplexed bus cycle sequencer. Accepts a request while idle,
// runs its T-states on the bus pins and pulses done on the final clock.
// Assumes the requester drops req_valid once it sees done.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int FETCH_T  = 4,
    parameter int XFER_T   = 3,
    localparam int TW      = $clog2(FETCH_T + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] bus_addr_hi,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [2:0]        bus_status
);

    logic [TW-1:0] tnum;
    logic          phase;
    logic          last;
    logic          active;
    logic          start;
    logic [2:0]    kind_q;
    logic [TW-1:0] cyc_len;
    logic          sel_addr;
    logic          capture;

    // Accept only legal kinds while idle; length follows the latched kind
    assign active  = (tnum != '0);
    assign start   = req_valid && !active && kind_legal(req_kind);
    assign cyc_len = (kind_q == K_FETCH) ? TW'(FETCH_T) : TW'(XFER_T);
    assign rsp_done = last;

    bus_tstate_ctrl #(.MAX_T(FETCH_T)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cyc_len (cyc_len),
        .tnum    (tnum),
        .phase   (phase),
        .last    (last)
    );

    bus_strobe_gen #(.TW(TW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tnum     (tnum),
        .phase    (phase),
        .rd_kind  (kind_reads(kind_q)),
        .wr_kind  (kind_writes(kind_q)),
        .ale      (bus_ale),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .ad_oe    (bus_ad_oe),
        .sel_addr (sel_addr),
        .capture  (capture)
    );

    bus_req_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_addr  (sel_addr),
        .capture   (capture),
        .ad_in     (bus_ad_in),
        .kind_q    (kind_q),
        .addr_hi   (bus_addr_hi),
        .ad_out    (bus_ad_out),
        .status    (bus_status),
        .rdata     (rsp_rdata)
    );

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !rsp_done));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_t4_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tnum == TW'(4)) |-> (bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe));

endmodule

// File: tb/bus_cycle_seq_tb.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module bus_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [7:0]  bus_addr_hi;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in;
    logic        bus_ale;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [2:0]  bus_status;
    logic [7:0]  mem_val = 8'h00;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // Memory model: byte present only while the read strobe is low
    assign bus_ad_in = !bus_rd_n ? mem_val : 8'hEE;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_status(bus_status)
    );

    // {kind, addr, wdata, memory byte}
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 16'h2000, 8'h00, 8'h06},
        {3'd1, 16'h2001, 8'h00, 8'h43},
        {3'd2, 16'h526A, 8'h9C, 8'h00},
        {3'd3, 16'h41C0, 8'h00, 8'h5E},
        {3'd4, 16'hBE7F, 8'hA5, 8'h00},
        {3'd0, 16'hFFFF, 8'h00, 8'hFF},
        {3'd1, 16'h0000, 8'h00, 8'h00},
        {3'd2, 16'h8001, 8'h01, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rv);
        bit rd_k = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
        bit wr_k = (k == 3'd2) || (k == 3'd4);
        bit io_k = (k == 3'd3) || (k == 3'd4);
        int exp_len = (k == 3'd0) ? 8 : 6;
        logic [7:0] ehi = io_k ? a[7:0] : a[15:8];
        int done_at = 0;
        int done_cnt = 0;
        bit e_r1 = 0, e_r2 = 0, e_r3 = 0, e_r4 = 0, e_r5 = 0, e_r7 = 0, e_r8 = 0;
        logic [7:0] rd_got = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; mem_val = rv;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_addr = ~a; req_wdata = ~wd;   // R11: latched copy must steer the cycle
            end
            if (n <= exp_len) begin
                bit win = (n >= 3) && (n <= 5);
                if (bus_status != exp_status(k)) e_r2 = 1;
                if (bus_ale != (n == 1)) e_r3 = 1;
                if (n == 1 && (!bus_ad_oe || bus_ad_out != a[7:0])) e_r3 = 1;
                if (bus_addr_hi != ehi) e_r4 = 1;
                if (rd_k && (bus_rd_n != !win)) e_r5 = 1;
                if (rd_k && n >= 2 && bus_ad_oe) e_r5 = 1;
                if (!rd_k && !bus_rd_n) e_r5 = 1;
                if (wr_k && (bus_wr_n != !win)) e_r7 = 1;
                if (wr_k && win && (!bus_ad_oe || bus_ad_out != wd)) e_r7 = 1;
                if (!wr_k && !bus_wr_n) e_r7 = 1;
                if (n >= 7 && (!bus_rd_n || !bus_wr_n || bus_ale || bus_ad_oe)) e_r8 = 1;
            end
            if (rsp_done) begin
                done_cnt++;
                if (done_at == 0) begin
                    done_at = n;
                    rd_got = rsp_rdata;
                end
                req_valid = 1'b0;
            end
            if (n > exp_len && !bus_ale && bus_rd_n && bus_wr_n && done_at == 0) e_r1 = 1;
        end
        req_valid = 1'b0;
        check(done_at == exp_len, "R1 cycle length", done_at, exp_len);
        check(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
        check(!e_r2, "R2 status code", bus_status, exp_status(k));
        check(!e_r3, "R3 ALE and low address", 1, 0);
        check(!e_r4, "R4 address bytes", bus_addr_hi, ehi);
        check(!e_r5 && !e_r11_dummy(), "R5 read strobe window", 1, 0);
        check(!e_r7, "R7 write strobe and data", 1, 0);
        if (k == 3'd0) check(!e_r8, "R8 fetch T4 quiet", 1, 0);
        if (rd_k) check(rd_got == rv, "R6 read data capture", rd_got, rv);
        if (e_r1) check(0, "R1 no done", 0, 1);
    endtask

    function automatic bit e_r11_dummy();
        return 1'b0;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !rsp_done,
              "R9 reset idle strobes", {bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe, rsp_done}, 5'b11000);
        check(bus_status == 3'b000, "R9 reset status", bus_status, 0);

        for (int i = 0; i < 8; i++) begin
            logic [34:0] v = VEC[i];
            run_cycle(v[34:32], v[31:16], v[15:8], v[7:0]);
        end

        // R10: illegal kind codes are ignored
        for (int k = 5; k < 8; k++) begin
            bit moved = 0;
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
            for (int n = 0; n < 10; n++) begin
                @(negedge clk);
                if (bus_ale || !bus_rd_n || !bus_wr_n || rsp_done || bus_status != 3'b000 || bus_ad_oe)
                    moved = 1;
            end
            req_valid = 1'b0;
            check(!moved, "R10 illegal kind ignored", moved, 0);
        end

        // R9: synchronous reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h3344; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!bus_wr_n, "R7 write strobe before reset", bus_wr_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe && !rsp_done && bus_status == 3'b000,
              "R9 mid-cycle reset idle", {bus_wr_n, bus_ad_oe, bus_status}, 5'b10000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_wr_n && !rsp_done, "R9 stays idle after reset", bus_wr_n, 1);

        // R11: run again after reset; request changes mid-cycle are ignored
        run_cycle(3'd3, 16'h00C0, 8'h00, 8'hA7);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule